// File: doc/BRIEF.md
# ECC Chunk Status Accumulator

This block sits behind a page-oriented error-correction decoder. The decoder supplies one 8-bit status code for each chunk it has processed. The block sorts every code into one of four classes:

- clean
- erased
- corrected with a bit count
- uncorrectable

It keeps running page totals from these classes: the worst single-chunk bitflip count, the saturating sum of corrected bits, the number of failed chunks and a sticky failure flag.

A clear input opens a new page. A status that carries the last-chunk marker closes the page and raises a done flag. The page result output carries the worst-chunk count while every chunk was recoverable, and an all-ones failure marker once any chunk was lost. A closed page holds its results, and any further statuses are dropped until the next clear. The decoding logic that produces the codes is outside this block.

Top module: `ecc_status_accum`

## Requirements
- R1: After reset, max_flips_o, total_flips_o, bad_chunks_o, page_fail_o and page_done_o are all zero.
- R2: Code 0x00 (clean chunk) and code 0xFF (erased chunk) change no output other than page_done_o.
- R3: A code from 0x01 to 0x28 adds its value to total_flips_o and raises max_flips_o to that value when it is larger than the current maximum.
- R4: Code 0xFE, and any code from 0x29 to 0xFD, increments bad_chunks_o and sets page_fail_o, which then stays set until a clear.
- R5: total_flips_o is 16 bits wide and saturates at 0xFFFF instead of wrapping.
- R6: page_result_o equals max_flips_o while page_fail_o is low, and equals 0xFF while page_fail_o is high.
- R7: A status accepted with last_i high sets page_done_o one cycle later. While page_done_o is high, statuses are ignored and all results hold until a clear.
- R8: clear_i zeroes all accumulators and page_done_o. If valid_i is high in the same cycle, that status is applied to the fresh page, including its last_i.
- R9: A cycle with valid_i low and clear_i low changes no output.
- R10: bad_chunks_o is 8 bits wide and saturates at 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Start a new page, zeroing the accumulators |
| valid_i | input | 1 | Qualifies code_i and last_i |
| code_i | input | 8 | Chunk status code |
| last_i | input | 1 | Marks the final chunk of the page |
| max_flips_o | output | 8 | Largest corrected-bit count in any chunk |
| total_flips_o | output | 16 | Saturating sum of corrected bits |
| bad_chunks_o | output | 8 | Saturating count of uncorrectable chunks |
| page_fail_o | output | 1 | Sticky flag: some chunk was uncorrectable |
| page_result_o | output | 8 | Worst-chunk count, or 0xFF on failure |
| page_done_o | output | 1 | Page summary final |

## Verification
Every result is registered. The effect of a status presented before a rising edge therefore appears on all outputs one cycle later, and page_result_o follows with no extra delay, because it is a combinational choice between two registers.

The bench drives inputs on the falling edge. A behavioural model updates on the rising edge from the same inputs, and every output is compared with that model at the next falling edge, exactly one register stage after the stimulus. Directed checks are made at the falling edge after an idle cycle, so the final accepted status has always landed. They cover:
- the clear-with-status collision
- the two saturation limits
- statuses dropped after a page closes

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;
  typedef enum logic [1:0] {
    CK_CLEAN  = 2'd0,
    CK_ERASED = 2'd1,
    CK_FIXED  = 2'd2,
    CK_BAD    = 2'd3
  } chunk_kind_e;
endpackage

// File: rtl/ecc_code_classify.sv
module ecc_code_classify
  import ecc_stat_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int MAX_FIX = 40
) (
  input  logic [CODE_W-1:0] code_i,
  output chunk_kind_e       kind_o,
  output logic [CODE_W-1:0] flips_o
);
  localparam logic [CODE_W-1:0] ErasedCode = '1;
  localparam logic [CODE_W-1:0] FixLimit   = CODE_W'(MAX_FIX);

  always_comb begin
    flips_o = '0;
    if (code_i == '0)              kind_o = CK_CLEAN;
    else if (code_i == ErasedCode) kind_o = CK_ERASED;
    else if (code_i > FixLimit)    kind_o = CK_BAD;   // includes the explicit uncorrectable code
    else begin
      kind_o  = CK_FIXED;
      flips_o = code_i;
    end
  end
endmodule

// File: rtl/ecc_page_accum.sv
module ecc_page_accum
  import ecc_stat_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int MAX_FIX = 40,
  parameter int TOT_W   = 16,
  parameter int FCNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              accept_i,
  input  chunk_kind_e       kind_i,
  input  logic [CODE_W-1:0] flips_i,
  output logic [CODE_W-1:0] max_o,
  output logic [TOT_W-1:0]  total_o,
  output logic [FCNT_W-1:0] fcnt_o,
  output logic              fail_o
);
  localparam logic [TOT_W-1:0]  TotMax  = '1;
  localparam logic [FCNT_W-1:0] FcntMax = '1;

  logic [CODE_W-1:0] max_base, max_d;
  logic [TOT_W-1:0]  tot_base, tot_d;
  logic [FCNT_W-1:0] fcnt_base, fcnt_d;
  logic              fail_base, fail_d;
  logic [TOT_W:0]    tot_sum;

  always_comb begin
    max_base  = clear_i ? '0 : max_o;
    tot_base  = clear_i ? '0 : total_o;
    fcnt_base = clear_i ? '0 : fcnt_o;
    fail_base = clear_i ? 1'b0 : fail_o;
    tot_sum   = {1'b0, tot_base} + (TOT_W+1)'(flips_i);
    max_d  = max_base;
    tot_d  = tot_base;
    fcnt_d = fcnt_base;
    fail_d = fail_base;
    if (accept_i) begin
      unique case (kind_i)
        CK_FIXED: begin
          tot_d = tot_sum[TOT_W] ? TotMax : tot_sum[TOT_W-1:0];
          if (flips_i > max_base) max_d = flips_i;
        end
        CK_BAD: begin
          fail_d = 1'b1;
          if (fcnt_base != FcntMax) fcnt_d = fcnt_base + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_o   <= '0;
      total_o <= '0;
      fcnt_o  <= '0;
      fail_o  <= 1'b0;
    end else begin
      max_o   <= max_d;
      total_o <= tot_d;
      fcnt_o  <= fcnt_d;
      fail_o  <= fail_d;
    end
  end

  assert_max_ceiling_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    max_o <= CODE_W'(MAX_FIX));
  assert_total_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> total_o >= $past(total_o));
  assert_fail_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !clear_i |=> fail_o);
  assert_fail_matches_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o == (fcnt_o != '0));
  assert_fcnt_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> fcnt_o >= $past(fcnt_o));
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i && !clear_i |=> $stable(total_o) && $stable(max_o) && $stable(fcnt_o));
endmodule

// File: rtl/ecc_status_accum.sv
module ecc_status_accum
  import ecc_stat_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int MAX_FIX = 40,
  parameter int TOT_W   = 16,
  parameter int FCNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              last_i,
  output logic [CODE_W-1:0] max_flips_o,
  output logic [TOT_W-1:0]  total_flips_o,
  output logic [FCNT_W-1:0] bad_chunks_o,
  output logic              page_fail_o,
  output logic [CODE_W-1:0] page_result_o,
  output logic              page_done_o
);
  chunk_kind_e       kind;
  logic [CODE_W-1:0] flips;
  logic              accept;
  logic              done_d;

  // a closed page ignores statuses; clear reopens it in the same cycle
  assign accept = valid_i && (clear_i || !page_done_o);

  ecc_code_classify #(.CODE_W(CODE_W), .MAX_FIX(MAX_FIX)) i_classify (
    .code_i (code_i),
    .kind_o (kind),
    .flips_o(flips)
  );

  ecc_page_accum #(.CODE_W(CODE_W), .MAX_FIX(MAX_FIX), .TOT_W(TOT_W), .FCNT_W(FCNT_W)) i_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .accept_i(accept),
    .kind_i  (kind),
    .flips_i (flips),
    .max_o   (max_flips_o),
    .total_o (total_flips_o),
    .fcnt_o  (bad_chunks_o),
    .fail_o  (page_fail_o)
  );

  always_comb begin
    done_d = clear_i ? 1'b0 : page_done_o;
    if (accept && last_i) done_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) page_done_o <= 1'b0;
    else         page_done_o <= done_d;
  end

  assign page_result_o = page_fail_o ? '1 : max_flips_o;

  assert_done_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_done_o && !clear_i |=> page_done_o && $stable(total_flips_o)
      && $stable(bad_chunks_o) && $stable(max_flips_o));
  assert_clear_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !valid_i |=> total_flips_o == '0 && bad_chunks_o == '0 && !page_done_o);
  assert_last_closes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && last_i && (clear_i || !page_done_o) |=> page_done_o);
endmodule

// File: tb/test_ecc_status_accum.sv
module test_ecc_status_accum;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0, valid = 1'b0, last = 1'b0;
  logic [7:0] code = 8'h00;
  logic [7:0]  max_o, res_o, bad_o;
  logic [15:0] tot_o;
  logic        fail_o, done_o;

  int checks = 0, errors = 0, cyc = 0;
  bit live = 1'b0;
  int m_max = 0, m_tot = 0, m_bad = 0, m_fail = 0, m_done = 0;

  always #4 clk = ~clk;  // 125 MHz

  ecc_status_accum i_ecc_status_accum (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .valid_i(valid), .code_i(code),
    .last_i(last), .max_flips_o(max_o), .total_flips_o(tot_o), .bad_chunks_o(bad_o),
    .page_fail_o(fail_o), .page_result_o(res_o), .page_done_o(done_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_max = 0; m_tot = 0; m_bad = 0; m_fail = 0; m_done = 0;
    end else begin
      bit acc;
      acc = valid && (clear || m_done == 0);
      if (clear) begin
        m_max = 0; m_tot = 0; m_bad = 0; m_fail = 0; m_done = 0;
      end
      if (acc) begin
        int c;
        c = int'(code);
        if (c == 0 || c == 255) begin end
        else if (c > 40) begin
          m_fail = 1;
          if (m_bad < 255) m_bad++;
        end else begin
          m_tot = (m_tot + c > 65535) ? 65535 : m_tot + c;
          if (c > m_max) m_max = c;
        end
        if (last) m_done = 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      chk("R3 max_flips", int'(max_o), m_max);
      chk("R5 total_flips", int'(tot_o), m_tot);
      chk("R10 bad_chunks", int'(bad_o), m_bad);
      chk("R4 page_fail", int'(fail_o), m_fail);
      chk("R6 page_result", int'(res_o), m_fail != 0 ? 255 : m_max);
      chk("R7 page_done", int'(done_o), m_done);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      finish_run();
    end
  end

  task automatic put(input bit c, input bit v, input logic [7:0] k, input bit l);
    @(negedge clk);
    clear = c; valid = v; code = k; last = l;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(0, 0, 8'h00, 0);
  endtask

  initial begin
    logic [7:0] lfsr;
    repeat (3) @(negedge clk);
    chk("R1 reset total", int'(tot_o), 0);
    chk("R1 reset max", int'(max_o), 0);
    chk("R1 reset bad", int'(bad_o), 0);
    chk("R1 reset fail", int'(fail_o), 0);
    chk("R1 reset done", int'(done_o), 0);
    rst_n = 1'b1;
    live = 1'b1;

    // R2 and R3: clean, erased and corrected chunks
    put(1, 0, 8'h00, 0);
    put(0, 1, 8'h00, 0);
    put(0, 1, 8'hFF, 0);
    idle(1);
    chk("R2 clean/erased total", int'(tot_o), 0);
    chk("R2 clean/erased max", int'(max_o), 0);
    put(0, 1, 8'd5, 0);
    put(0, 1, 8'd12, 0);
    put(0, 1, 8'd3, 1);
    idle(1);
    chk("R3 total", int'(tot_o), 20);
    chk("R3 max", int'(max_o), 12);
    chk("R6 result no fail", int'(res_o), 12);
    chk("R7 done", int'(done_o), 1);

    // R9: idle cycles change nothing
    idle(4);
    chk("R9 idle total", int'(tot_o), 20);

    // R7: statuses after done are dropped
    put(0, 1, 8'd30, 0);
    put(0, 1, 8'hFE, 1);
    idle(1);
    chk("R7 ignored total", int'(tot_o), 20);
    chk("R7 ignored fail", int'(fail_o), 0);

    // R4 and R6: failing page
    put(1, 0, 8'h00, 0);
    put(0, 1, 8'hFE, 0);
    put(0, 1, 8'd7, 0);
    put(0, 1, 8'h29, 0);
    put(0, 1, 8'h28, 1);
    idle(1);
    chk("R4 bad count", int'(bad_o), 2);
    chk("R4 fail flag", int'(fail_o), 1);
    chk("R6 result on fail", int'(res_o), 255);
    chk("R3 max at ceiling", int'(max_o), 40);

    // R8: clear with a status in the same cycle
    put(1, 1, 8'd9, 0);
    idle(1);
    chk("R8 fresh total", int'(tot_o), 9);
    chk("R8 fresh fail", int'(fail_o), 0);
    put(1, 1, 8'hFD, 1);
    idle(1);
    chk("R8 clear+last done", int'(done_o), 1);
    chk("R8 clear+last bad", int'(bad_o), 1);

    // R5: saturation of the corrected-bit total
    put(1, 0, 8'h00, 0);
    for (int i = 0; i < 1700; i++) put(0, 1, 8'd40, 0);
    idle(1);
    chk("R5 total saturated", int'(tot_o), 65535);

    // R10: saturation of the failed-chunk count
    put(1, 0, 8'h00, 0);
    for (int i = 0; i < 300; i++) put(0, 1, 8'hFE, 0);
    idle(1);
    chk("R10 bad saturated", int'(bad_o), 255);

    // mixed pseudo-random codes, model compared every cycle
    lfsr = 8'hA5;
    for (int p = 0; p < 20; p++) begin
      put(1, 0, 8'h00, 0);
      for (int i = 0; i < 8; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        put(0, lfsr[0] | lfsr[1], (lfsr[7:6] == 2'b11) ? lfsr : {2'b00, lfsr[5:0]}, i == 7);
      end
      idle(2);
    end

    idle(2);
    live = 1'b0;
    finish_run();
  end
endmodule